// File: doc/BRIEF.md
# Write-Back Pixel Cache with Per-Byte Dirty Tags

This block is a small on-chip pixel cache. It holds eight blocks of 256 bits. Three ports reach the storage. A wide port loads whole blocks from the memory array and hands whole blocks back for writeback. A 32-bit write port and a 32-bit read port serve the pixel datapath. All three ports may work in the same cycle.

Every byte in the cache has its own dirty flag. A 32-bit word write raises the flags of the bytes it stores. A block load clears all 32 flags of that block. When a block is written back, its flags come out beside the data as a byte-enable mask. The array then rewrites only the bytes that changed. Which block holds which frame-buffer line is decided outside this block.

Top module: `px_wb_cache`

## Requirements
- R1: A synchronous active-high reset clears every dirty flag, drives `rd_data` to zero and drives `wb_valid` low. A writeback of any block straight after reset returns an all-zero `wb_mask`.
- R2: A word write stores into the word at `wr_addr`. `wr_addr[5:3]` selects the block and `wr_addr[2:0]` selects the word within that block. Only the bytes whose `wr_be` bit is set are stored. Bit k of `wr_be` controls `wr_data[8k+7:8k]`. The other bytes of the word keep their old value.
- R3: When `rd_en` is high at a clock edge, `rd_data` shows the word at `rd_addr` one cycle later. The value is the word as it stood before that edge. The result is unspecified if the same edge writes that word or loads its block.
- R4: A word write to word w with `wr_be` bit k set sets dirty bit 4w+k of the addressed block.
- R5: A block load (`ld_en`, `ld_idx`) replaces all 32 bytes of the block with `ld_data` and clears all 32 of its dirty bits.
- R6: If a load and a word write target the same block at the same edge, the load wins. The block holds `ld_data` and its dirty tag ends up all zero.
- R7: A load, a word write, a word read and a writeback that target different blocks all complete correctly in the same cycle.
- R8: When `wb_en` is high at an edge, `wb_valid` is high for exactly the next cycle. In that cycle `wb_data` holds block `wb_idx` as it stood before the edge, and `wb_mask` holds the dirty tag. Bit j of `wb_mask` flags `wb_data[8j+7:8j]`. A writeback does not change the data or the tag, so a repeated writeback returns the same mask.
- R9: A dirty tag changes only on a word write or a block load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Word write strobe |
| wr_addr | input | 6 | Word write address {block, word} |
| wr_be | input | 4 | Byte enables of the word write |
| wr_data | input | 32 | Word write data |
| rd_en | input | 1 | Word read strobe |
| rd_addr | input | 6 | Word read address {block, word} |
| rd_data | output | 32 | Registered word read data |
| ld_en | input | 1 | Block load strobe from the array |
| ld_idx | input | 3 | Block index of the load |
| ld_data | input | 256 | Block load data |
| wb_en | input | 1 | Writeback request |
| wb_idx | input | 3 | Block index of the writeback |
| wb_valid | output | 1 | Writeback data and mask are valid |
| wb_data | output | 256 | Block data being written back |
| wb_mask | output | 32 | Byte-enable mask for the writeback (dirty tag) |

## Verification
The bench aims at a load and a word write that land on the same block in one edge. If the design let the write win, or merged the write's dirty bits into the tag, a stale byte or a set mask bit would appear at the next writeback. Partial byte enables check that the disabled bytes of a word keep their value and stay clean. A byte-lane slip would corrupt neighbours or raise the wrong mask bits. Writebacks are issued in the same cycle as writes to the same block, and are issued twice in a row. A design that returned post-edge contents, or cleared the tag on writeback, would show a different mask.

// File: rtl/px_cache_pkg.sv
package px_cache_pkg;
  parameter int unsigned PXC_BLOCKS  = 8;
  parameter int unsigned PXC_BLK_W   = 256;
  parameter int unsigned PXC_WORD_W  = 32;
  parameter int unsigned PXC_BYTE_W  = 8;
endpackage

// File: rtl/px_byte_lane.sv
// One byte column across all blocks: two write ports (load, word write),
// two asynchronous read ports (word read, writeback).
module px_byte_lane #(
  parameter int unsigned NBLK   = 8,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned IDX_W = $clog2(NBLK)
) (
  input  logic              clk,
  input  logic              ld_we,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [BYTE_W-1:0] ld_byte,
  input  logic              wr_we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [BYTE_W-1:0] wr_byte,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [BYTE_W-1:0] rd_byte,
  input  logic [IDX_W-1:0]  wb_idx,
  output logic [BYTE_W-1:0] wb_byte
);
  logic [BYTE_W-1:0] mem [NBLK];

  // Load is written last so it wins if both ever target one entry.
  always_ff @(posedge clk) begin
    if (wr_we) mem[wr_idx] <= wr_byte;
    if (ld_we) mem[ld_idx] <= ld_byte;
  end

  assign rd_byte = mem[rd_idx];
  assign wb_byte = mem[wb_idx];
endmodule

// File: rtl/px_dirty_tags.sv
// Per-block byte dirty tags: set by word writes, cleared by block loads.
module px_dirty_tags #(
  parameter int unsigned NBLK  = 8,
  parameter int unsigned TAG_W = 32,
  localparam int unsigned IDX_W = $clog2(NBLK)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_we,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [TAG_W-1:0] set_bits,
  input  logic             clr_we,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag
);
  logic [NBLK-1:0][TAG_W-1:0] tags;

  always_ff @(posedge clk) begin
    if (rst) begin
      tags <= '0;
    end else begin
      if (set_we) tags[set_idx] <= tags[set_idx] | set_bits;
      if (clr_we) tags[clr_idx] <= '0;
    end
  end

  assign rd_tag = tags[rd_idx];

  assert_load_clears_R5: assert property (@(posedge clk) disable iff (rst)
    clr_we |=> (tags[$past(clr_idx)] == '0));

  assert_write_marks_R4: assert property (@(posedge clk) disable iff (rst)
    (set_we && !(clr_we && clr_idx == set_idx))
      |=> ((tags[$past(set_idx)] & $past(set_bits)) == $past(set_bits)));

  assert_tag_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (!set_we && !clr_we) |=> $stable(tags));
endmodule

// File: rtl/px_wb_cache.sv
module px_wb_cache
  import px_cache_pkg::*;
#(
  parameter int unsigned NBLK   = PXC_BLOCKS,
  parameter int unsigned BLK_W  = PXC_BLK_W,
  parameter int unsigned WORD_W = PXC_WORD_W,
  parameter int unsigned BYTE_W = PXC_BYTE_W,
  localparam int unsigned NBYTE  = BLK_W / BYTE_W,
  localparam int unsigned NWORD  = BLK_W / WORD_W,
  localparam int unsigned BPW    = WORD_W / BYTE_W,
  localparam int unsigned IDX_W  = $clog2(NBLK),
  localparam int unsigned WSEL_W = $clog2(NWORD),
  localparam int unsigned ADDR_W = IDX_W + WSEL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BPW-1:0]    wr_be,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [BLK_W-1:0]  ld_data,
  input  logic              wb_en,
  input  logic [IDX_W-1:0]  wb_idx,
  output logic              wb_valid,
  output logic [BLK_W-1:0]  wb_data,
  output logic [NBYTE-1:0]  wb_mask
);
  logic [IDX_W-1:0]  wr_blk, rd_blk;
  logic [WSEL_W-1:0] wr_word, rd_word;
  logic              ld_collide, wr_go;
  logic [NBYTE-1:0]  wr_bits, wb_tag;
  logic [BLK_W-1:0]  rd_vec, wb_vec;

  assign wr_blk     = wr_addr[ADDR_W-1:WSEL_W];
  assign wr_word    = wr_addr[WSEL_W-1:0];
  assign rd_blk     = rd_addr[ADDR_W-1:WSEL_W];
  assign rd_word    = rd_addr[WSEL_W-1:0];
  // Load beats a word write aimed at the same block.
  assign ld_collide = ld_en && wr_en && (ld_idx == wr_blk);
  assign wr_go      = wr_en && !ld_collide;
  assign wr_bits    = NBYTE'(wr_be) << (wr_word * BPW);

  for (genvar j = 0; j < NBYTE; j++) begin : g_lane
    localparam int unsigned LW = j / BPW;
    localparam int unsigned LK = j % BPW;
    logic lane_we;
    assign lane_we = wr_go && (wr_word == WSEL_W'(LW)) && wr_be[LK];
    px_byte_lane #(.NBLK(NBLK), .BYTE_W(BYTE_W)) u_lane (
      .clk     (clk),
      .ld_we   (ld_en),
      .ld_idx  (ld_idx),
      .ld_byte (ld_data[j*BYTE_W +: BYTE_W]),
      .wr_we   (lane_we),
      .wr_idx  (wr_blk),
      .wr_byte (wr_data[LK*BYTE_W +: BYTE_W]),
      .rd_idx  (rd_blk),
      .rd_byte (rd_vec[j*BYTE_W +: BYTE_W]),
      .wb_idx  (wb_idx),
      .wb_byte (wb_vec[j*BYTE_W +: BYTE_W])
    );
  end

  px_dirty_tags #(.NBLK(NBLK), .TAG_W(NBYTE)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .set_we   (wr_go),
    .set_idx  (wr_blk),
    .set_bits (wr_bits),
    .clr_we   (ld_en),
    .clr_idx  (ld_idx),
    .rd_idx   (wb_idx),
    .rd_tag   (wb_tag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      wb_valid <= 1'b0;
      wb_data  <= '0;
      wb_mask  <= '0;
    end else begin
      if (rd_en) rd_data <= rd_vec[rd_word*WORD_W +: WORD_W];
      wb_valid <= wb_en;
      if (wb_en) begin
        wb_data <= wb_vec;
        wb_mask <= wb_tag;
      end
    end
  end

  assert_wb_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    wb_en |=> wb_valid);

  assert_wb_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !wb_en |=> !wb_valid);
endmodule

// File: tb/px_wb_cache_tb.sv
`timescale 1ns/1ps
module px_wb_cache_tb;
  logic         clk = 1'b0;
  logic         rst;
  logic         wr_en, rd_en, ld_en, wb_en;
  logic [5:0]   wr_addr, rd_addr;
  logic [3:0]   wr_be;
  logic [31:0]  wr_data, rd_data;
  logic [2:0]   ld_idx, wb_idx;
  logic [255:0] ld_data, wb_data;
  logic         wb_valid;
  logic [31:0]  wb_mask;

  int nchk = 0;
  int nfail = 0;

  logic [255:0] m_data  [8];
  logic [31:0]  m_tag   [8];
  logic [31:0]  m_known [8];

  always #10 clk = ~clk;

  px_wb_cache u_dut (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_valid(wb_valid),
    .wb_data(wb_data), .wb_mask(wb_mask)
  );

  function automatic logic [255:0] expand(input logic [31:0] bm);
    logic [255:0] r;
    for (int j = 0; j < 32; j++) r[8*j +: 8] = {8{bm[j]}};
    return r;
  endfunction

  task automatic check(input string rq, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wr_en = 0; rd_en = 0; ld_en = 0; wb_en = 0;
    wr_addr = '0; rd_addr = '0; wr_be = '0; wr_data = '0;
    ld_idx = '0; wb_idx = '0; ld_data = '0;
  endtask

  // Inputs are set before the call (at a falling edge); checks run at the next falling edge.
  task automatic run_cycle(input string rq);
    logic         s_wb, rd_chk;
    logic [255:0] e_wb_data, e_wb_km;
    logic [31:0]  e_wb_mask, e_rd, e_rd_km;
    logic [2:0]   rb, wb_b;
    logic [2:0]   rw, ww;
    s_wb = wb_en;
    e_wb_data = m_data[wb_idx];
    e_wb_km   = expand(m_known[wb_idx]);
    e_wb_mask = m_tag[wb_idx];
    rb = rd_addr[5:3]; rw = rd_addr[2:0];
    wb_b = wr_addr[5:3]; ww = wr_addr[2:0];
    e_rd    = m_data[rb][32*rw +: 32];
    e_rd_km = expand(m_known[rb])[32*rw +: 32];
    rd_chk = rd_en && !(ld_en && ld_idx == rb)
             && !(wr_en && wr_addr == rd_addr && wr_be != 0);
    // model update: word write first, then load overrides the whole block
    if (wr_en && !(ld_en && ld_idx == wb_b)) begin
      for (int k = 0; k < 4; k++) begin
        if (wr_be[k]) begin
          m_data[wb_b][8*(4*ww+k) +: 8] = wr_data[8*k +: 8];
          m_tag[wb_b][4*ww+k]   = 1'b1;
          m_known[wb_b][4*ww+k] = 1'b1;
        end
      end
    end
    if (ld_en) begin
      m_data[ld_idx]  = ld_data;
      m_tag[ld_idx]   = '0;
      m_known[ld_idx] = '1;
    end
    @(posedge clk);
    @(negedge clk);
    check(rq, "wb_valid", {255'b0, wb_valid}, {255'b0, s_wb});
    if (s_wb) begin
      check(rq, "wb_mask", {224'b0, wb_mask}, {224'b0, e_wb_mask});
      check(rq, "wb_data", wb_data & e_wb_km, e_wb_data & e_wb_km);
    end
    if (rd_chk)
      check(rq, "rd_data", {224'b0, rd_data & e_rd_km}, {224'b0, e_rd & e_rd_km});
  endtask

  task automatic do_wb(input logic [2:0] b, input string rq);
    idle_inputs(); wb_en = 1; wb_idx = b; run_cycle(rq);
  endtask

  initial begin
    #4_000_000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] junk;
    junk = $urandom(32'h5EED_0042);
    for (int b = 0; b < 8; b++) begin
      m_data[b] = '0; m_tag[b] = '0; m_known[b] = '0;
    end
    idle_inputs();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1: reset state of outputs and tags
    check("R1", "rd_data after reset", {224'b0, rd_data}, '0);
    check("R1", "wb_valid after reset", {255'b0, wb_valid}, '0);
    for (int b = 0; b < 8; b++) do_wb(3'(b), "R1");

    // R2: full write then partial byte-enable write, read back
    idle_inputs(); wr_en = 1; wr_addr = {3'd2, 3'd5}; wr_be = 4'hF; wr_data = 32'hAABBCCDD;
    run_cycle("R2");
    idle_inputs(); wr_en = 1; wr_addr = {3'd2, 3'd5}; wr_be = 4'b0101; wr_data = 32'h11223344;
    run_cycle("R2");
    idle_inputs(); rd_en = 1; rd_addr = {3'd2, 3'd5};
    run_cycle("R3");
    check("R2", "merged word", {224'b0, rd_data}, {224'b0, 32'hAA22CC44});

    // R4: single byte write on a clean loaded block marks one bit
    idle_inputs(); ld_en = 1; ld_idx = 3'd6; ld_data = {8{$urandom}}; run_cycle("R5");
    idle_inputs(); wr_en = 1; wr_addr = {3'd6, 3'd7}; wr_be = 4'b1000; wr_data = $urandom;
    run_cycle("R4");
    do_wb(3'd6, "R4");
    check("R4", "single dirty bit", {224'b0, wb_mask}, {224'b0, 32'h8000_0000});

    // R8: writeback in the same cycle as a write returns pre-edge contents
    idle_inputs(); wr_en = 1; wr_addr = {3'd6, 3'd0}; wr_be = 4'hF; wr_data = 32'hDEADBEEF;
    wb_en = 1; wb_idx = 3'd6; run_cycle("R8");
    do_wb(3'd6, "R8");
    do_wb(3'd6, "R8");
    check("R8", "repeat mask", {224'b0, wb_mask}, {224'b0, 32'h8000_000F});

    // R5: load block 2 clears tag and replaces data
    idle_inputs(); ld_en = 1; ld_idx = 3'd2; ld_data = {8{$urandom}}; run_cycle("R5");
    do_wb(3'd2, "R5");
    check("R5", "mask after load", {224'b0, wb_mask}, '0);

    // R6: load and write to same block in one edge
    idle_inputs(); ld_en = 1; ld_idx = 3'd4; ld_data = {8{32'h0F0F_0F0F}};
    wr_en = 1; wr_addr = {3'd4, 3'd1}; wr_be = 4'hF; wr_data = 32'h1234_5678;
    run_cycle("R6");
    do_wb(3'd4, "R6");
    check("R6", "mask after collision", {224'b0, wb_mask}, '0);
    check("R6", "data after collision", wb_data, {8{32'h0F0F_0F0F}});

    // R7: four operations on four blocks in one cycle
    idle_inputs(); ld_en = 1; ld_idx = 3'd0; ld_data = {8{$urandom}};
    wr_en = 1; wr_addr = {3'd1, 3'd3}; wr_be = 4'b0110; wr_data = $urandom;
    rd_en = 1; rd_addr = {3'd2, 3'd0};
    wb_en = 1; wb_idx = 3'd6;
    run_cycle("R7");
    do_wb(3'd1, "R7");
    check("R7", "mask of written block", {224'b0, wb_mask}, {224'b0, 32'h0000_6000});

    // R9: idle cycles with reads and writebacks only leave tags alone
    idle_inputs(); rd_en = 1; rd_addr = {3'd1, 3'd3}; run_cycle("R9");
    idle_inputs(); run_cycle("R9");
    do_wb(3'd1, "R9");
    check("R9", "mask after idle", {224'b0, wb_mask}, {224'b0, 32'h0000_6000});

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      idle_inputs();
      wr_en   = ($urandom % 3) != 0;
      wr_addr = 6'($urandom);
      wr_be   = 4'($urandom);
      wr_data = $urandom;
      rd_en   = $urandom % 2;
      rd_addr = 6'($urandom);
      ld_en   = ($urandom % 6) == 0;
      ld_idx  = 3'($urandom);
      ld_data = {8{$urandom}};
      wb_en   = ($urandom % 3) == 0;
      wb_idx  = 3'($urandom);
      run_cycle("R7");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule